// File: doc/BRIEF.md
# Coprime Task Slot Scheduler

This block picks which hardware task may issue an instruction on each clock. It walks a table of slots, one slot per clock, and the slot names the task that owns that clock. A shared memory bus offers this core an access window on a fixed period. The table length and the bus period share no common factor, so over a full cycle of both, every task in the table lands on the bus window the same number of times.

The walk never stops. If the task named by the current slot is not ready, or is waiting for an event that has not yet arrived, the slot is lost and a bubble goes out. The walk then moves on to the next slot. Events that pulse while a waiting task is between turns are caught in a per-task latch, so the task still wakes up on its next turn. The execution pipeline that consumes the issue stream is outside this block.

Top module: `coprime_slot_sched`

## Requirements
- R1: While reset is low, `issue_valid`, `bus_win` and `issue_on_win` are 0. The slot pointer and the bus phase both start at 0, so the first clock after reset serves slot 0 and is a bus window.
- R2: The slot pointer moves forward by one on every clock, whatever state the tasks are in, and wraps from `NUM_SLOTS-1` back to 0. Edge k after reset serves slot k mod `NUM_SLOTS`.
- R3: `bus_win` is 1 on edge k after reset exactly when k mod `BUS_PERIOD` is 0.
- R4: Slot s occupies bits `[s*(TASK_W+1) +: TASK_W+1]` of `slot_table`. Its MSB is the valid flag and its low `TASK_W` bits are the task number. An invalid slot, or a task number at or above `NUM_TASKS`, produces a bubble: `issue_valid`=0 and `issue_task`=0. `issue_task` is 0 for every bubble.
- R5: A slot whose task has `task_ready` low becomes a bubble. The next clock still serves the next slot.
- R6: A task with `task_wait` high and no pending event is skipped in its slot.
- R7: A pulse on `task_event[t]` is held until task t issues while waiting. A later waiting turn of t then issues and clears the held event, so the turn after that is skipped again if no new event arrives.
- R8: An event pulse in the same clock as a waiting task's own slot lets it issue at once, and no event is left pending afterwards.
- R9: `issue_on_win` is 1 exactly when an issue happens on a bus window.
- R10: With 15 slots, a bus period of 8 and slot s owned by task s mod 3, each of tasks 0, 1 and 2 issues on exactly 5 windows in 120 clocks.
- R11: With 16 slots, a bus period of 8 and slot s owned by task s mod 4, only task 0 ever issues on a window: 15 of 15 windows in 120 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_table | input | NUM_SLOTS*(TASK_W+1) | Packed slot entries, each a valid flag followed by a task number |
| task_ready | input | NUM_TASKS | Per-task ready flag |
| task_wait | input | NUM_TASKS | Per-task flag: the task is blocked until an event arrives |
| task_event | input | NUM_TASKS | Per-task event pulse |
| issue_valid | output | 1 | A task issues on this clock |
| issue_task | output | TASK_W | Number of the issuing task, 0 on a bubble |
| bus_win | output | 1 | This clock is the core's bus window |
| issue_on_win | output | 1 | An issue falls on the bus window |

## Verification
The bench builds two copies of the block side by side. One has 15 slots, a bus period of 8 and 4 tasks; the other differs only in having 16 slots. Running both through the same 120 clocks shows the coprime table giving each task an equal share of windows, while the 16-slot table locks tasks 1 to 3 out of the window entirely. The 15-slot copy also runs a cycle-by-cycle vector sequence covering ready drops, waits, held events, same-clock events and the pointer wrap. A directed case checks an invalid slot.

// File: rtl/css_pkg.sv
package css_pkg;

    // Default geometry: a 15-entry slot table against an 8-clock bus period.
    localparam int unsigned CSS_SLOTS_DEF  = 15;
    localparam int unsigned CSS_PERIOD_DEF = 8;
    localparam int unsigned CSS_TASKS_DEF  = 4;

    // Bits needed to count 0..n-1, never less than one.
    function automatic int unsigned css_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/css_mod_counter.sv
module css_mod_counter
    import css_pkg::*;
#(
    parameter  int unsigned MODULUS = 8,
    localparam int unsigned CW      = css_bits(MODULUS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] count
);

    localparam logic [CW-1:0] LAST = CW'(MODULUS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/css_event_trap.sv
module css_event_trap #(
    parameter int unsigned NUM_TASKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TASKS-1:0] evt,
    input  logic [NUM_TASKS-1:0] consume,
    output logic [NUM_TASKS-1:0] pending
);

    typedef struct packed {
        logic [NUM_TASKS-1:0] held;
    } trap_st_t;

    trap_st_t st_d, st_q;

    // An event counts for its task from the clock it arrives in.
    for (genvar t = 0; t < NUM_TASKS; t++) begin : g_lane
        assign pending[t] = st_q.held[t] | evt[t];
    end

    always_comb begin
        st_d      = st_q;
        st_d.held = (st_q.held | evt) & ~consume;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/coprime_slot_sched.sv
module coprime_slot_sched
    import css_pkg::*;
#(
    parameter  int unsigned NUM_SLOTS  = CSS_SLOTS_DEF,
    parameter  int unsigned BUS_PERIOD = CSS_PERIOD_DEF,
    parameter  int unsigned NUM_TASKS  = CSS_TASKS_DEF,
    localparam int unsigned TASK_W     = css_bits(NUM_TASKS),
    localparam int unsigned ENTRY_W    = TASK_W + 1,
    localparam int unsigned PTR_W      = css_bits(NUM_SLOTS),
    localparam int unsigned PH_W       = css_bits(BUS_PERIOD),
    localparam int unsigned TASK_SPAN  = 1 << TASK_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SLOTS*ENTRY_W-1:0] slot_table,
    input  logic [NUM_TASKS-1:0]         task_ready,
    input  logic [NUM_TASKS-1:0]         task_wait,
    input  logic [NUM_TASKS-1:0]         task_event,
    output logic                         issue_valid,
    output logic [TASK_W-1:0]            issue_task,
    output logic                         bus_win,
    output logic                         issue_on_win
);

    typedef struct packed {
        logic              valid;
        logic [TASK_W-1:0] tsk;
        logic              win;
        logic              on_win;
    } issue_st_t;

    issue_st_t out_d, out_q;

    logic [PTR_W-1:0]     slot_ptr_q;
    logic [PH_W-1:0]      bus_phase_q;
    logic [NUM_TASKS-1:0] pend;
    logic [NUM_TASKS-1:0] consume;

    logic [ENTRY_W-1:0] slot_arr [NUM_SLOTS];
    logic [TASK_SPAN-1:0] rdy_p, wt_p, pend_p;

    logic [ENTRY_W-1:0] cur;
    logic [TASK_W-1:0]  cur_tid;
    logic               go;
    logic               win_now;

    // Slot pointer and bus phase both run free from reset.
    css_mod_counter #(.MODULUS(NUM_SLOTS)) u_slot_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .count (slot_ptr_q)
    );

    css_mod_counter #(.MODULUS(BUS_PERIOD)) u_phase_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .count (bus_phase_q)
    );

    css_event_trap #(.NUM_TASKS(NUM_TASKS)) u_trap (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (task_event),
        .consume (consume),
        .pending (pend)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign slot_arr[s] = slot_table[s*ENTRY_W +: ENTRY_W];
    end

    // Widen the per-task vectors to every code a slot can hold; codes past
    // the last task read as never ready, which turns them into bubbles.
    for (genvar t = 0; t < TASK_SPAN; t++) begin : g_pad
        if (t < NUM_TASKS) begin : g_real
            assign rdy_p[t]  = task_ready[t];
            assign wt_p[t]   = task_wait[t];
            assign pend_p[t] = pend[t];
        end else begin : g_none
            assign rdy_p[t]  = 1'b0;
            assign wt_p[t]   = 1'b0;
            assign pend_p[t] = 1'b0;
        end
    end

    always_comb begin
        cur     = slot_arr[slot_ptr_q];
        cur_tid = cur[TASK_W-1:0];
        win_now = (bus_phase_q == '0);
        go      = cur[ENTRY_W-1] & rdy_p[cur_tid] &
                  (~wt_p[cur_tid] | pend_p[cur_tid]);

        consume = '0;
        for (int t = 0; t < NUM_TASKS; t++) begin
            if (go && wt_p[cur_tid] && (cur_tid == TASK_W'(t))) begin
                consume[t] = 1'b1;
            end
        end

        out_d        = out_q;
        out_d.valid  = go;
        out_d.tsk    = go ? cur_tid : '0;
        out_d.win    = win_now;
        out_d.on_win = go & win_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign issue_valid  = out_q.valid;
    assign issue_task   = out_q.tsk;
    assign bus_win      = out_q.win;
    assign issue_on_win = out_q.on_win;

endmodule

// File: rtl/css_sched_chk.sv
module css_sched_chk
    import css_pkg::*;
#(
    parameter  int unsigned NUM_SLOTS  = CSS_SLOTS_DEF,
    parameter  int unsigned BUS_PERIOD = CSS_PERIOD_DEF,
    parameter  int unsigned NUM_TASKS  = CSS_TASKS_DEF,
    localparam int unsigned TASK_W     = css_bits(NUM_TASKS),
    localparam int unsigned PTR_W      = css_bits(NUM_SLOTS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_TASKS-1:0] task_ready,
    input logic                 issue_valid,
    input logic [TASK_W-1:0]    issue_task,
    input logic                 bus_win,
    input logic                 issue_on_win,
    input logic [PTR_W-1:0]     slot_ptr
);

    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_SLOTS - 1);

    logic [NUM_TASKS-1:0] ready_q;
    int unsigned          gap_q;
    logic                 seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= '0;
            gap_q   <= 0;
            seen_q  <= 1'b0;
        end else begin
            ready_q <= task_ready;
            if (bus_win) begin
                gap_q  <= 0;
                seen_q <= 1'b1;
            end else begin
                gap_q <= gap_q + 1;
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!issue_valid && !bus_win && !issue_on_win));

    assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_ptr == PTR_LAST) |=> (slot_ptr == '0));

    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_ptr != PTR_LAST) |=> (slot_ptr == $past(slot_ptr) + 1'b1));

    assert_win_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_win && seen_q) |-> (gap_q == BUS_PERIOD - 1));

    assert_win_no_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_win && seen_q) |-> (gap_q < BUS_PERIOD - 1));

    assert_bubble_task_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_valid |-> (issue_task == '0));

    assert_ready_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ready_q[issue_task]);

    assert_on_win_R9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_on_win |-> (issue_valid && bus_win));

    assert_win_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && bus_win) |-> issue_on_win);

endmodule

bind coprime_slot_sched css_sched_chk #(
    .NUM_SLOTS  (NUM_SLOTS),
    .BUS_PERIOD (BUS_PERIOD),
    .NUM_TASKS  (NUM_TASKS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .task_ready   (task_ready),
    .issue_valid  (issue_valid),
    .issue_task   (issue_task),
    .bus_win      (bus_win),
    .issue_on_win (issue_on_win),
    .slot_ptr     (slot_ptr_q)
);

// File: tb/coprime_slot_sched_tb_top.sv
module coprime_slot_sched_tb_top;

    localparam int CLK_P = 10;
    localparam int EW    = 3;   // valid flag + 2-bit task number
    localparam int NVEC  = 17;

    logic clk = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    logic              rst_n;
    logic [15*EW-1:0]  tab15;
    logic [16*EW-1:0]  tab16;
    logic [3:0]        rdy, wt, ev;

    logic       v15, w15, ow15, v16, w16, ow16;
    logic [1:0] t15, t16;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    coprime_slot_sched #(.NUM_SLOTS(15), .BUS_PERIOD(8), .NUM_TASKS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .slot_table(tab15),
        .task_ready(rdy), .task_wait(wt), .task_event(ev),
        .issue_valid(v15), .issue_task(t15), .bus_win(w15), .issue_on_win(ow15)
    );

    coprime_slot_sched #(.NUM_SLOTS(16), .BUS_PERIOD(8), .NUM_TASKS(4)) dut16_i (
        .clk(clk), .rst_n(rst_n), .slot_table(tab16),
        .task_ready(4'hF), .task_wait(4'h0), .task_event(4'h0),
        .issue_valid(v16), .issue_task(t16), .bus_win(w16), .issue_on_win(ow16)
    );

    // {ready, wait, event, expected valid, expected task, expected on-window}
    // Vector k is applied before edge k after reset; slot k owns task (k mod 15) mod 3.
    localparam logic [15:0] VECS [NVEC] = '{
        {4'hF, 4'h0, 4'h0, 1'b1, 2'd0, 1'b1},  // k0  slot0 t0 on window
        {4'hD, 4'h0, 4'h0, 1'b0, 2'd0, 1'b0},  // k1  t1 not ready
        {4'hF, 4'h4, 4'h0, 1'b0, 2'd0, 1'b0},  // k2  t2 waits, nothing held
        {4'hF, 4'h4, 4'h4, 1'b1, 2'd0, 1'b0},  // k3  event for t2 off-turn
        {4'hF, 4'h4, 4'h0, 1'b1, 2'd1, 1'b0},  // k4
        {4'hF, 4'h4, 4'h0, 1'b1, 2'd2, 1'b0},  // k5  held event wakes t2
        {4'hF, 4'h0, 4'h0, 1'b1, 2'd0, 1'b0},  // k6
        {4'hF, 4'h0, 4'h0, 1'b1, 2'd1, 1'b0},  // k7
        {4'hF, 4'h4, 4'h0, 1'b0, 2'd0, 1'b0},  // k8  held event was used up
        {4'hF, 4'h1, 4'h1, 1'b1, 2'd0, 1'b0},  // k9  same-clock event for t0
        {4'hF, 4'h0, 4'h0, 1'b1, 2'd1, 1'b0},  // k10
        {4'hF, 4'h0, 4'h0, 1'b1, 2'd2, 1'b0},  // k11
        {4'hF, 4'h1, 4'h0, 1'b0, 2'd0, 1'b0},  // k12 nothing left for t0
        {4'hF, 4'h0, 4'h0, 1'b1, 2'd1, 1'b0},  // k13
        {4'hF, 4'h0, 4'h0, 1'b1, 2'd2, 1'b0},  // k14
        {4'hF, 4'h0, 4'h0, 1'b1, 2'd0, 1'b0},  // k15 wrapped to slot0
        {4'hF, 4'h0, 4'h0, 1'b1, 2'd1, 1'b1}   // k16 slot1 on window
    };

    function automatic logic [15*EW-1:0] mk15(input int modv, input int hole);
        logic [15*EW-1:0] r;
        for (int s = 0; s < 15; s++) begin
            r[s*EW +: EW] = (s == hole) ? 3'b000 : {1'b1, 2'(s % modv)};
        end
        return r;
    endfunction

    function automatic logic [16*EW-1:0] mk16(input int modv);
        logic [16*EW-1:0] r;
        for (int s = 0; s < 16; s++) begin
            r[s*EW +: EW] = {1'b1, 2'(s % modv)};
        end
        return r;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic restart();
        @(negedge clk);
        rst_n = 1'b0;
        rdy = 4'hF; wt = 4'h0; ev = 4'h0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        int c15 [4];
        int c16 [4];
        rst_n = 1'b0;
        rdy = 4'h0; wt = 4'h0; ev = 4'h0;
        tab15 = mk15(3, -1);
        tab16 = mk16(4);

        // R1: outputs quiet in reset
        repeat (3) @(posedge clk);
        #(CLK_P/4);
        check("R1 issue_valid in reset", int'(v15), 0);
        check("R1 bus_win in reset", int'(w15), 0);
        check("R1 issue_on_win in reset", int'(ow15), 0);

        // Vector walk: R5 R6 R7 R8 on valid, R2 on task, R9 on on-window, R3 on window
        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            if (k == 0) rst_n = 1'b1;
            {rdy, wt, ev} = VECS[k][15:4];
            @(posedge clk);
            #(CLK_P/4);
            check($sformatf("R5 R6 R7 R8 valid k%0d", k), int'(v15), int'(VECS[k][3]));
            check($sformatf("R2 R4 task k%0d", k), int'(t15), int'(VECS[k][2:1]));
            check($sformatf("R9 on_win k%0d", k), int'(ow15), int'(VECS[k][0]));
            check($sformatf("R3 bus_win k%0d", k), int'(w15), (k % 8 == 0) ? 1 : 0);
        end

        // Coprime contrast: 15 vs 16 slots over 120 clocks (R10, R11)
        restart();
        for (int i = 0; i < 4; i++) begin c15[i] = 0; c16[i] = 0; end
        for (int k = 0; k < 120; k++) begin
            @(posedge clk);
            #(CLK_P/4);
            if (ow15) c15[t15]++;
            if (ow16) c16[t16]++;
            check($sformatf("R2 slot task k%0d", k), int'(t15), (k % 15) % 3);
            check($sformatf("R3 window k%0d", k), int'(w15), (k % 8 == 0) ? 1 : 0);
        end
        check("R10 task0 window issues", c15[0], 5);
        check("R10 task1 window issues", c15[1], 5);
        check("R10 task2 window issues", c15[2], 5);
        check("R10 task3 window issues", c15[3], 0);
        check("R11 task0 window issues", c16[0], 15);
        check("R11 task1 window issues", c16[1], 0);
        check("R11 task2 window issues", c16[2], 0);
        check("R11 task3 window issues", c16[3], 0);

        // R4: invalid slot 3 is a bubble; R5: slot 4 still follows next clock
        tab15 = mk15(3, 3);
        restart();
        for (int k = 0; k < 5; k++) begin
            @(posedge clk);
            #(CLK_P/4);
            if (k == 3) begin
                check("R4 invalid slot valid", int'(v15), 0);
                check("R4 invalid slot task", int'(t15), 0);
            end
            if (k == 4) begin
                check("R5 no stall valid", int'(v15), 1);
                check("R5 no stall task", int'(t15), 1);
            end
        end

        finish_run();
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule